// File: doc/BRIEF.md
# Interrupt Acceptance and Refresh Unit

This unit sits beside the sequencer of an 8-bit processor core. Each time the sequencer reaches an instruction boundary it raises a strobe. The unit then chooses one of three outcomes:

- take the non-maskable interrupt,
- take the maskable interrupt in the current dispatch mode,
- or let the next opcode fetch start.

A core that is halted instead stays parked at the boundary. The unit owns all the state behind this choice: the two interrupt-enable flip-flops, the countdown that delays a deferred enable, the dispatch-mode register, the halted flag and the 7-bit memory refresh counter.

The sequencer reports what it does through single-cycle strobes:

- enable, disable, return-from-interrupt and return-from-NMI;
- mode set, with a 2-bit mode value;
- halt;
- opcode fetch and prefix fetch.

The unit answers with a registered action code, the flag states, the refresh register and the data-bus value the core should see. While the core is halted, that data-bus value is forced to all ones.

Top module: `cpu_irq_refresh`

## Requirements
- R1: After reset both enable flags are 0, the enable countdown is 0, the mode is 0, the refresh register is 0x00, the core is not halted, no NMI is pending and `act_vld_o` is 0.
- R2: An enable strobe loads the countdown with 2 and sets no flag. Each boundary decrements a nonzero countdown. At the boundary where it goes from 1 to 0, both flags become 1, and a maskable request present at that same boundary is already taken.
- R3: A disable strobe outside a boundary clears both enable flags in the next cycle.
- R4: A rising edge on `nmi_i` latches one pending NMI, so a pulse of any length is accepted exactly once. At a boundary a pending NMI wins over a maskable request. On acceptance, flag 2 takes the value of flag 1 (after any enable that expires at that boundary) and flag 1 is cleared.
- R5: A maskable request is taken only at a boundary where enable flag 1 is set and `int_i` is high. Taking it clears both flags and the countdown.
- R6: Each boundary produces, one cycle later, `act_vld_o`=1 with `act_o`: 0 fetch, 1 NMI, 2 maskable in mode 0, 3 maskable in mode 1, 4 maskable in mode 2, 5 stay halted. A mode-set strobe with value 3 leaves the mode unchanged.
- R7: The return-from-interrupt and return-from-NMI strobes both copy enable flag 2 into flag 1.
- R8: The halt strobe sets the halted flag. A boundary while halted with no interrupt taken gives action 5 and never a fetch. Taking either interrupt clears the halted flag.
- R9: The refresh register counts in its low 7 bits modulo 128, and bit 7 keeps its value. A load strobe writes all 8 bits.
- R10: The refresh register advances by one for each of these in a cycle, added together: an opcode-fetch strobe; a prefix-fetch strobe whose second-prefix flag is 0; a boundary that takes an interrupt or stays halted.
- R11: `db_o` is 0xFF while halted, and otherwise `db_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Deferred enable strobe |
| di_i | input | 1 | Disable strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| mode_set_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode value to write |
| nmi_i | input | 1 | Non-maskable request line |
| int_i | input | 1 | Maskable request line |
| halt_i | input | 1 | Halt strobe |
| op_fetch_i | input | 1 | Opcode fetch strobe |
| prefix_fetch_i | input | 1 | Prefix byte fetch strobe |
| prefix_second_i | input | 1 | Prefix being fetched is the second of a pair |
| r_load_i | input | 1 | Refresh register write strobe |
| r_data_i | input | 8 | Refresh register write value |
| db_i | input | 8 | Data bus from memory |
| act_o | output | 3 | Action code of the last boundary |
| act_vld_o | output | 1 | Action code valid for one cycle |
| iff1_o | output | 1 | Enable flag 1 |
| iff2_o | output | 1 | Enable flag 2 |
| ei_wait_o | output | 2 | Deferred enable countdown |
| mode_o | output | 2 | Dispatch mode |
| halted_o | output | 1 | Halted flag |
| nmi_pend_o | output | 1 | NMI latched and not yet taken |
| r_o | output | 8 | Refresh register |
| db_o | output | 8 | Data bus value seen by the core |

## Verification
Every strobe is applied for one cycle and updates state at that clock edge. The flags, countdown, mode, halted flag and refresh register are therefore due one cycle after the strobe. The bench reads them one time unit after that edge, before it changes any input. The action code is also registered at the boundary edge, so it is read in the same slot as the flags that the decision changed. The forced data-bus value is combinational from the halted flag and is read while the flag is set. An NMI edge needs one cycle to be latched before a boundary can take it, so the bench raises `nmi_i` at least one cycle ahead of the boundary that is meant to accept it.

// File: rtl/irq_refresh_pkg.sv
package irq_refresh_pkg;

  typedef enum logic [2:0] {
    ACT_FETCH = 3'd0,
    ACT_NMI   = 3'd1,
    ACT_INT0  = 3'd2,
    ACT_INT1  = 3'd3,
    ACT_INT2  = 3'd4,
    ACT_STAY  = 3'd5
  } act_e;

  // Advance the low bits of the refresh register by n, keep the top bit.
  function automatic logic [7:0] refresh_bump(input logic [7:0] r, input logic [1:0] n);
    logic [6:0] low;
    low = r[6:0] + {5'd0, n};
    return {r[7], low};
  endfunction

  // Map a dispatch mode to its action code.
  function automatic act_e mode_to_act(input logic [1:0] m);
    act_e a;
    case (m)
      2'd1:    a = ACT_INT1;
      2'd2:    a = ACT_INT2;
      default: a = ACT_INT0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int EI_DELAY = 2,
  localparam int CW = $clog2(EI_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          ret_i,
  input  logic          take_nmi_i,
  input  logic          take_int_i,
  output logic          iff1_o,
  output logic          iff2_o,
  output logic          iff1_eff_o,
  output logic [CW-1:0] wait_o
);
  logic          iff1_q, iff2_q;
  logic [CW-1:0] wait_q;
  logic          expiring;

  assign expiring   = (wait_q == CW'(1));
  assign iff1_eff_o = iff1_q | expiring;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      wait_q <= '0;
    end else if (boundary_i) begin
      if (take_int_i)          wait_q <= '0;
      else if (wait_q != '0)   wait_q <= wait_q - CW'(1);
      if (take_nmi_i) begin
        iff2_q <= iff1_eff_o;
        iff1_q <= 1'b0;
      end else if (take_int_i) begin
        iff1_q <= 1'b0;
        iff2_q <= 1'b0;
      end else if (expiring) begin
        iff1_q <= 1'b1;
        iff2_q <= 1'b1;
      end
    end else if (di_i) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (ei_i) begin
      wait_q <= CW'(EI_DELAY);
    end else if (ret_i) begin
      iff1_q <= iff2_q;
    end
  end

  assign iff1_o = iff1_q;
  assign iff2_o = iff2_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic prev_q, pend_q, rise;

  assign rise = nmi_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= (pend_q & ~take_i) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_decider.sv
module irq_decider
  import irq_refresh_pkg::*;
(
  input  logic       boundary_i,
  input  logic       nmi_pend_i,
  input  logic       iff1_eff_i,
  input  logic       int_i,
  input  logic       halted_i,
  input  logic [1:0] mode_i,
  output logic       take_nmi_o,
  output logic       take_int_o,
  output logic       stay_o,
  output act_e       act_o
);
  always_comb begin
    take_nmi_o = 1'b0;
    take_int_o = 1'b0;
    stay_o     = 1'b0;
    act_o      = ACT_FETCH;
    if (boundary_i) begin
      if (nmi_pend_i) begin
        take_nmi_o = 1'b1;
        act_o      = ACT_NMI;
      end else if (iff1_eff_i && int_i) begin
        take_int_o = 1'b1;
        act_o      = mode_to_act(mode_i);
      end else if (halted_i) begin
        stay_o = 1'b1;
        act_o  = ACT_STAY;
      end
    end
  end
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter
  import irq_refresh_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [RW-1:0] load_val_i,
  input  logic [1:0]    n_inc_i,
  output logic [RW-1:0] r_o
);
  logic [RW-1:0] r_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            r_q <= '0;
    else if (load_i)       r_q <= load_val_i;
    else if (n_inc_i != 0) r_q <= refresh_bump(r_q, n_inc_i);
  end

  assign r_o = r_q;
endmodule

// File: rtl/cpu_irq_refresh.sv
module cpu_irq_refresh
  import irq_refresh_pkg::*;
#(
  parameter int EI_DELAY = 2,
  parameter int DW       = 8,
  localparam int CW      = $clog2(EI_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          reti_i,
  input  logic          retn_i,
  input  logic          mode_set_i,
  input  logic [1:0]    mode_i,
  input  logic          nmi_i,
  input  logic          int_i,
  input  logic          halt_i,
  input  logic          op_fetch_i,
  input  logic          prefix_fetch_i,
  input  logic          prefix_second_i,
  input  logic          r_load_i,
  input  logic [DW-1:0] r_data_i,
  input  logic [DW-1:0] db_i,
  output logic [2:0]    act_o,
  output logic          act_vld_o,
  output logic          iff1_o,
  output logic          iff2_o,
  output logic [CW-1:0] ei_wait_o,
  output logic [1:0]    mode_o,
  output logic          halted_o,
  output logic          nmi_pend_o,
  output logic [DW-1:0] r_o,
  output logic [DW-1:0] db_o
);
  // named internal events
  logic       take_nmi, take_int, stay, iff1_eff, accept;
  act_e       act_now;
  logic [1:0] mode_q;
  logic       halted_q;
  logic [2:0] act_q;
  logic       act_vld_q;
  logic [1:0] n_inc;

  nmi_edge_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_i(take_nmi), .pend_o(nmi_pend_o)
  );

  irq_enable_ctrl #(.EI_DELAY(EI_DELAY)) u_en (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
    .ret_i(reti_i | retn_i), .take_nmi_i(take_nmi), .take_int_i(take_int),
    .iff1_o(iff1_o), .iff2_o(iff2_o), .iff1_eff_o(iff1_eff), .wait_o(ei_wait_o)
  );

  irq_decider u_dec (
    .boundary_i(boundary_i), .nmi_pend_i(nmi_pend_o), .iff1_eff_i(iff1_eff),
    .int_i(int_i), .halted_i(halted_q), .mode_i(mode_q),
    .take_nmi_o(take_nmi), .take_int_o(take_int), .stay_o(stay), .act_o(act_now)
  );

  assign accept = take_nmi | take_int;
  assign n_inc  = 2'({1'b0, op_fetch_i})
                + 2'({1'b0, prefix_fetch_i & ~prefix_second_i})
                + 2'({1'b0, accept | stay});

  refresh_counter #(.RW(DW)) u_ref (
    .clk(clk), .rst_n(rst_n), .load_i(r_load_i), .load_val_i(r_data_i),
    .n_inc_i(n_inc), .r_o(r_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 2'd0;
      halted_q  <= 1'b0;
      act_q     <= ACT_FETCH;
      act_vld_q <= 1'b0;
    end else begin
      if (mode_set_i && mode_i != 2'd3) mode_q <= mode_i;
      if (accept)      halted_q <= 1'b0;
      else if (halt_i) halted_q <= 1'b1;
      act_vld_q <= boundary_i;
      if (boundary_i) act_q <= act_now;
    end
  end

  assign mode_o    = mode_q;
  assign halted_o  = halted_q;
  assign act_o     = act_q;
  assign act_vld_o = act_vld_q;
  assign db_o      = halted_q ? {DW{1'b1}} : db_i;
endmodule

// File: rtl/irq_refresh_checker.sv
module irq_refresh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary_i,
  input logic       di_i,
  input logic       r_load_i,
  input logic [2:0] act_o,
  input logic       act_vld_o,
  input logic       iff1_o,
  input logic       iff2_o,
  input logic [1:0] ei_wait_o,
  input logic       halted_o,
  input logic [7:0] r_o
);
  assert_di_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (di_i && !boundary_i) |=> (!iff1_o && !iff2_o));

  assert_nmi_drops_iff1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld_o && act_o == 3'd1) |-> !iff1_o);

  assert_int_clears_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld_o && act_o >= 3'd2 && act_o <= 3'd4) |-> (!iff1_o && !iff2_o && ei_wait_o == 2'd0));

  assert_no_fetch_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld_o && act_o == 3'd0) |-> !$past(halted_o));

  assert_top_bit_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !r_load_i |=> $stable(r_o[7]));

  assert_wait_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ei_wait_o <= 2'd2);
endmodule

bind cpu_irq_refresh irq_refresh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .di_i(di_i), .r_load_i(r_load_i),
  .act_o(act_o), .act_vld_o(act_vld_o), .iff1_o(iff1_o), .iff2_o(iff2_o),
  .ei_wait_o(ei_wait_o), .halted_o(halted_o), .r_o(r_o)
);

// File: tb/test_cpu_irq_refresh.sv
module test_cpu_irq_refresh;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 0, ei_i = 0, di_i = 0, reti_i = 0, retn_i = 0, mode_set_i = 0;
  logic [1:0] mode_i = 0;
  logic nmi_i = 0, int_i = 0, halt_i = 0, op_fetch_i = 0, prefix_fetch_i = 0, prefix_second_i = 0;
  logic r_load_i = 0;
  logic [7:0] r_data_i = 0, db_i = 0;
  logic [2:0] act_o;
  logic act_vld_o, iff1_o, iff2_o, halted_o, nmi_pend_o;
  logic [1:0] ei_wait_o, mode_o;
  logic [7:0] r_o, db_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cpu_irq_refresh i_cpu_irq_refresh (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
    .reti_i(reti_i), .retn_i(retn_i), .mode_set_i(mode_set_i), .mode_i(mode_i),
    .nmi_i(nmi_i), .int_i(int_i), .halt_i(halt_i), .op_fetch_i(op_fetch_i),
    .prefix_fetch_i(prefix_fetch_i), .prefix_second_i(prefix_second_i),
    .r_load_i(r_load_i), .r_data_i(r_data_i), .db_i(db_i), .act_o(act_o),
    .act_vld_o(act_vld_o), .iff1_o(iff1_o), .iff2_o(iff2_o), .ei_wait_o(ei_wait_o),
    .mode_o(mode_o), .halted_o(halted_o), .nmi_pend_o(nmi_pend_o), .r_o(r_o), .db_o(db_o)
  );

  // stimulus {ei,di,reti,retn,bnd,irq,nmi,opf} | expected {vld,act,iff1,iff2,r[6:0]}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {8'b00000001, 1'b0, 3'd0, 2'b00, 7'd1},  // R10 opcode fetch
    {8'b10000000, 1'b0, 3'd0, 2'b00, 7'd1},  // R2 enable, no flag yet
    {8'b00001000, 1'b1, 3'd0, 2'b00, 7'd1},  // R2 first boundary
    {8'b00001100, 1'b1, 3'd2, 2'b00, 7'd2},  // R2 R5 taken on expiry, mode 0
    {8'b10000000, 1'b0, 3'd0, 2'b00, 7'd2},  // R2
    {8'b00001000, 1'b1, 3'd0, 2'b00, 7'd2},  // R2
    {8'b00001000, 1'b1, 3'd0, 2'b11, 7'd2},  // R2 flags set
    {8'b00000010, 1'b0, 3'd0, 2'b11, 7'd2},  // R4 edge latched
    {8'b00001010, 1'b1, 3'd1, 2'b01, 7'd3},  // R4 taken, flag saved
    {8'b00001110, 1'b1, 3'd0, 2'b01, 7'd3},  // R4 R5 held line no retake, iff1 off
    {8'b00010000, 1'b0, 3'd0, 2'b11, 7'd3},  // R7 return from NMI
    {8'b01000000, 1'b0, 3'd0, 2'b00, 7'd3},  // R3 disable
    {8'b00001100, 1'b1, 3'd0, 2'b00, 7'd3},  // R5 request ignored
    {8'b00100001, 1'b0, 3'd0, 2'b00, 7'd4}   // R7 R10 return copies 0
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 13:  return "R10";
      3:      return "R5";
      7, 8, 9: return "R4";
      10:     return "R7";
      11:     return "R3";
      12:     return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    boundary_i = 0; ei_i = 0; di_i = 0; reti_i = 0; retn_i = 0; mode_set_i = 0;
    int_i = 0; halt_i = 0; op_fetch_i = 0; prefix_fetch_i = 0; prefix_second_i = 0;
    r_load_i = 0;
  endtask

  task automatic bnd(input logic irq);
    boundary_i = 1; int_i = irq; tick(); clear_inputs();
  endtask

  task automatic pulse_ei();
    ei_i = 1; tick(); clear_inputs();
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_set_i = 1; mode_i = m; tick(); clear_inputs();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 act_vld", act_vld_o, 0);
    check("R1 flags", {iff1_o, iff2_o}, 0);
    check("R1 wait", ei_wait_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 refresh", r_o, 0);
    check("R1 halted", halted_o, 0);
    check("R1 nmi pend", nmi_pend_o, 0);

    for (int i = 0; i < NV; i++) begin
      {ei_i, di_i, reti_i, retn_i, boundary_i, int_i, nmi_i, op_fetch_i} = VEC[i][20:13];
      tick();
      check(row_tag(i), {act_vld_o, act_vld_o ? act_o : 3'd0, iff1_o, iff2_o, r_o[6:0]},
            {19'd0, VEC[i][12:0]});
      clear_inputs();
    end
    nmi_i = 0;

    // R6 dispatch modes and ignored mode 3
    set_mode(2'd1);
    check("R6 mode write", mode_o, 1);
    pulse_ei(); bnd(0); bnd(1);
    check("R6 mode 1 action", act_o, 3);
    set_mode(2'd3);
    check("R6 mode 3 ignored", mode_o, 1);
    set_mode(2'd2);
    pulse_ei(); bnd(0); bnd(1);
    check("R6 mode 2 action", act_o, 4);

    // R8 R11 halt behaviour, R9 wrap
    r_load_i = 1; r_data_i = 8'h7F; tick(); clear_inputs();
    check("R9 load", r_o, 8'h7F);
    db_i = 8'h3C;
    halt_i = 1; tick(); clear_inputs();
    check("R8 halted set", halted_o, 1);
    check("R11 forced bus", db_o, 8'hFF);
    bnd(0);
    check("R8 stay action", {act_vld_o, act_o}, {1'b1, 3'd5});
    check("R9 wrap in halt", r_o, 8'h00);
    pulse_ei(); bnd(0); bnd(1);
    check("R8 int leaves halt", {act_o, halted_o}, {3'd4, 1'b0});
    check("R11 bus passes", db_o, 8'h3C);

    // R9 R10 top bit and prefix counting
    r_load_i = 1; r_data_i = 8'hFF; tick(); clear_inputs();
    op_fetch_i = 1; tick(); clear_inputs();
    check("R9 top bit kept", r_o, 8'h80);
    prefix_fetch_i = 1; tick(); clear_inputs();
    check("R10 first prefix", r_o, 8'h81);
    prefix_fetch_i = 1; prefix_second_i = 1; tick(); clear_inputs();
    check("R10 second prefix", r_o, 8'h81);
    prefix_fetch_i = 1; op_fetch_i = 1; tick(); clear_inputs();
    check("R10 summed", r_o, 8'h83);

    // R4 long pulse accepted once, and priority over maskable
    nmi_i = 1; repeat (3) tick(); nmi_i = 0; tick();
    bnd(0);
    check("R4 nmi once a", act_o, 1);
    bnd(0);
    check("R4 nmi once b", act_o, 0);
    pulse_ei(); bnd(0); bnd(0);
    check("R2 flags up", {iff1_o, iff2_o}, 2'b11);
    nmi_i = 1; tick(); nmi_i = 0;
    bnd(1);
    check("R4 priority", {act_o, iff1_o, iff2_o}, {3'd1, 2'b01});
    reti_i = 1; tick(); clear_inputs();
    check("R7 return restores", {iff1_o, iff2_o}, 2'b11);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule